// File: doc/BRIEF.md
# Least-Squares Profile Detrend Unit

This block takes one short intensity profile of signed pixels, about twenty of them, of the kind read across an interferometric fringe pattern. It fits a straight line to the profile by least squares and removes that line from every pixel. It then streams the corrected pixels back out in their original order. Alongside each output beat it presents the fitted slope, the fitted intercept, and half the peak-to-peak span of the corrected profile. A later phase-estimation stage can use these to normalise the fringe.

The profile length, input width and fixed-point scaling are set at elaboration. Every division has a constant denominator, so each one is a multiply by a precomputed rounded reciprocal followed by an arithmetic right shift. The unit holds the profile in an internal register array and makes several passes over it: load and sum, mean, covariance, slope, intercept, and correct with span tracking. Only after those passes does it drain the result.

Back-pressure rules: input pixels transfer on a clock edge where `in_valid` and `in_ready` are both high. `in_ready` is high only while a profile is being loaded, and it drops from the edge that takes the last pixel until the last output beat has been taken. Output beats transfer on an edge where `out_valid` and `out_ready` are both high. While `out_valid` is high and `out_ready` is low, every output holds still.

Top module: `lsq_detrend`

## Requirements
- R1: After reset, `in_ready` is 1 and `out_valid` is 0.
- R2: A transferred pixel with `in_start`=1 becomes position 0 of a new profile and discards any partial one. Transferred pixels with `in_start`=0 while no profile is open are discarded. After the M-th pixel, `in_ready` stays 0 and no input is taken until the last output beat transfers.
- R3: Each pixel is scaled as p_i = in_i·2^SCALE_SH. The mean is ym = floor(S·RM / 2^RSH), where S = Σp_i and RM = round(2^RSH / M).
- R4: Slope = floor(C·RV / 2^(RSH-1)), where C = Σ(2i-(M-1))·(p_i-ym), V2 = M(M²-1)/3 and RV = round(2^RSH / V2).
- R5: Intercept = ym - floor(slope·(M-1)/2).
- R6: Output beat i (i = 0..M-1, in input order) carries q_i = p_i - intercept - slope·i.
- R7: `out_amp` = floor((max q - min q)/2) over the current profile only, because the extreme trackers restart with each profile.
- R8: `out_last` is 1 exactly on the M-th beat of a profile. While stalled (`out_valid`=1, `out_ready`=0), `out_data`, `out_last`, `out_slope`, `out_icpt` and `out_amp` do not change.
- R9: Full-scale inputs produce results equal to the formulas of R3–R7 with no overflow.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel present |
| in_ready | output | 1 | Unit can take a pixel |
| in_start | input | 1 | Pixel is position 0 of a profile |
| in_data | input | IN_W | Signed pixel intensity |
| out_valid | output | 1 | Output beat present |
| out_ready | input | 1 | Downstream takes the beat |
| out_data | output | OUT_W | Corrected pixel q_i, signed |
| out_last | output | 1 | Final beat of the profile |
| out_slope | output | OUT_W | Fitted slope, signed |
| out_icpt | output | OUT_W | Fitted intercept, signed |
| out_amp | output | OUT_W | Half peak-to-peak of corrected pixels |

## Verification
The fit is exercised with several kinds of profile, each of which exposes a different error:
- A flat profile gives a zero slope, and its small span after a large-span profile shows whether the extreme trackers restart.
- A pure ramp leaves near-zero residuals, which exposes a wrong sign or wrong scale in the slope or intercept.
- A triangle wave on a ramp, and random profiles sent with input gaps and output stalls, separate pass-ordering and hold errors from arithmetic errors.
- Full-scale alternating, constant-minimum and steep-ramp profiles show whether any accumulator truncates.
- Stray pixels sent before a start, and a profile restarted part-way through, check the framing rules.

// File: rtl/lsq_pkg.sv
package lsq_pkg;
  typedef enum logic [2:0] {
    ST_LOAD, ST_MEAN, ST_COV, ST_SLOPE, ST_ICPT, ST_CORR, ST_OUT
  } lsq_state_e;

  // rounded reciprocal of a constant denominator, scaled by 2^sh
  function automatic longint recip(input longint den, input int sh);
    return ((longint'(1) << sh) + den / 2) / den;
  endfunction
endpackage

// File: rtl/lsq_sample_buf.sv
module lsq_sample_buf #(
  parameter int M = 20,
  parameter int W = 30,
  localparam int IW = $clog2(M)
) (
  input  logic                clk,
  input  logic                we,
  input  logic [IW-1:0]       waddr,
  input  logic signed [W-1:0] wdata,
  input  logic [IW-1:0]       raddr,
  output logic signed [W-1:0] rdata
);
  logic signed [W-1:0] mem [M];

  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
  end

  assign rdata = mem[raddr];
endmodule

// File: rtl/lsq_line_fit.sv
module lsq_line_fit #(
  parameter int M = 20,
  parameter int OUT_W = 30,
  parameter int ACC_W = 37,
  parameter int RSH = 20
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    ld_first,
  input  logic                    ld_add,
  input  logic                    do_mean,
  input  logic                    cov_step,
  input  logic                    do_slope,
  input  logic                    do_icpt,
  input  logic                    corr_step,
  input  logic signed [OUT_W-1:0] px,
  input  logic signed [OUT_W-1:0] rd,
  output logic signed [OUT_W-1:0] slope,
  output logic signed [OUT_W-1:0] icpt,
  output logic signed [OUT_W-1:0] corr_val
);
  localparam int PROD_W = ACC_W + RSH + 2;
  localparam longint V2 = longint'(M) * (longint'(M) * M - 1) / 3;
  localparam logic signed [PROD_W-1:0] RM_P  = PROD_W'(lsq_pkg::recip(longint'(M), RSH));
  localparam logic signed [PROD_W-1:0] RV_P  = PROD_W'(lsq_pkg::recip(V2, RSH));
  localparam logic signed [PROD_W-1:0] KM1_P = PROD_W'(M - 1);
  localparam logic signed [ACC_W-1:0]  DPOS0 = ACC_W'(1 - M);

  logic signed [ACC_W-1:0]  sum_q, ym_q, cov_q, dpos_q, ramp_q;
  logic signed [ACC_W-1:0]  diff, term, cv;
  logic signed [PROD_W-1:0] prod_m, prod_s, prod_i;

  always_comb begin
    diff   = ACC_W'(rd) - ym_q;
    term   = dpos_q * diff;
    prod_m = PROD_W'(sum_q) * RM_P;
    prod_s = PROD_W'(cov_q) * RV_P;
    prod_i = PROD_W'(slope) * KM1_P;
    cv     = ACC_W'(rd) - ACC_W'(icpt) - ramp_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sum_q <= '0; ym_q <= '0; cov_q <= '0; dpos_q <= DPOS0;
      ramp_q <= '0; slope <= '0; icpt <= '0;
    end else begin
      if (ld_first) sum_q <= ACC_W'(px);
      else if (ld_add) sum_q <= sum_q + ACC_W'(px);
      if (do_mean) begin
        ym_q   <= ACC_W'(prod_m >>> RSH);
        cov_q  <= '0;
        dpos_q <= DPOS0;
      end
      if (cov_step) begin
        cov_q  <= cov_q + term;
        dpos_q <= dpos_q + ACC_W'(2);
      end
      if (do_slope) slope <= OUT_W'(prod_s >>> (RSH - 1));
      if (do_icpt) begin
        icpt   <= OUT_W'(ym_q - ACC_W'(prod_i >>> 1));
        ramp_q <= '0;
      end
      if (corr_step) ramp_q <= ramp_q + ACC_W'(slope);
    end
  end

  assign corr_val = OUT_W'(cv);
endmodule

// File: rtl/lsq_span_track.sv
module lsq_span_track #(
  parameter int W = 30
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                clr,
  input  logic                upd,
  input  logic signed [W-1:0] val,
  output logic signed [W-1:0] amp
);
  localparam logic signed [W-1:0] MOST_NEG = {1'b1, {(W-1){1'b0}}};
  localparam logic signed [W-1:0] MOST_POS = {1'b0, {(W-1){1'b1}}};

  logic signed [W-1:0] hi_q, lo_q;
  logic signed [W:0]   span;

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      hi_q <= MOST_NEG;
      lo_q <= MOST_POS;
    end else if (upd) begin
      if (val > hi_q) hi_q <= val;
      if (val < lo_q) lo_q <= val;
    end
  end

  assign span = (W+1)'(hi_q) - (W+1)'(lo_q);
  assign amp  = W'(span >>> 1);
endmodule

// File: rtl/lsq_detrend.sv
module lsq_detrend #(
  parameter int M = 20,
  parameter int IN_W = 12,
  parameter int SCALE_SH = 4,
  parameter int RSH = 20,
  parameter int OUT_W = IN_W + SCALE_SH + 2 * $clog2(M + 1) + 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    in_valid,
  output logic                    in_ready,
  input  logic                    in_start,
  input  logic signed [IN_W-1:0]  in_data,
  output logic                    out_valid,
  input  logic                    out_ready,
  output logic signed [OUT_W-1:0] out_data,
  output logic                    out_last,
  output logic signed [OUT_W-1:0] out_slope,
  output logic signed [OUT_W-1:0] out_icpt,
  output logic signed [OUT_W-1:0] out_amp
);
  import lsq_pkg::*;

  localparam int IW    = $clog2(M);
  localparam int ACC_W = OUT_W + $clog2(M + 1) + 2;
  localparam logic [IW-1:0] LAST = IW'(M - 1);

  lsq_state_e st_q;
  logic [IW-1:0] idx_q;
  logic armed_q;

  logic ld_first, ld_add, corr_step, buf_we;
  logic [IW-1:0] waddr;
  logic signed [OUT_W-1:0] px, rd, wdata, corr_val;

  assign px        = OUT_W'(in_data) <<< SCALE_SH;
  assign in_ready  = (st_q == ST_LOAD);
  assign ld_first  = in_ready && in_valid && in_start;
  assign ld_add    = in_ready && in_valid && !in_start && armed_q;
  assign corr_step = (st_q == ST_CORR);
  assign buf_we    = ld_first || ld_add || corr_step;
  assign waddr     = ld_first ? '0 : idx_q;
  assign wdata     = corr_step ? corr_val : px;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_q <= ST_LOAD;
      idx_q <= '0;
      armed_q <= 1'b0;
    end else begin
      unique case (st_q)
        ST_LOAD: begin
          if (ld_first) begin
            idx_q <= IW'(1);
            armed_q <= 1'b1;
          end else if (ld_add) begin
            if (idx_q == LAST) begin
              idx_q <= '0;
              armed_q <= 1'b0;
              st_q <= ST_MEAN;
            end else idx_q <= idx_q + IW'(1);
          end
        end
        ST_MEAN:  st_q <= ST_COV;
        ST_COV: begin
          if (idx_q == LAST) begin
            idx_q <= '0;
            st_q <= ST_SLOPE;
          end else idx_q <= idx_q + IW'(1);
        end
        ST_SLOPE: st_q <= ST_ICPT;
        ST_ICPT:  st_q <= ST_CORR;
        ST_CORR: begin
          if (idx_q == LAST) begin
            idx_q <= '0;
            st_q <= ST_OUT;
          end else idx_q <= idx_q + IW'(1);
        end
        ST_OUT: begin
          if (out_ready) begin
            if (idx_q == LAST) begin
              idx_q <= '0;
              st_q <= ST_LOAD;
            end else idx_q <= idx_q + IW'(1);
          end
        end
        default: st_q <= ST_LOAD;
      endcase
    end
  end

  lsq_sample_buf #(.M(M), .W(OUT_W)) u_buf (
    .clk(clk), .we(buf_we), .waddr(waddr), .wdata(wdata),
    .raddr(idx_q), .rdata(rd)
  );

  lsq_line_fit #(.M(M), .OUT_W(OUT_W), .ACC_W(ACC_W), .RSH(RSH)) u_fit (
    .clk(clk), .rst_n(rst_n),
    .ld_first(ld_first), .ld_add(ld_add),
    .do_mean(st_q == ST_MEAN), .cov_step(st_q == ST_COV),
    .do_slope(st_q == ST_SLOPE), .do_icpt(st_q == ST_ICPT),
    .corr_step(corr_step), .px(px), .rd(rd),
    .slope(out_slope), .icpt(out_icpt), .corr_val(corr_val)
  );

  lsq_span_track #(.W(OUT_W)) u_span (
    .clk(clk), .rst_n(rst_n), .clr(ld_first), .upd(corr_step),
    .val(corr_val), .amp(out_amp)
  );

  assign out_valid = (st_q == ST_OUT);
  assign out_last  = out_valid && (idx_q == LAST);
  assign out_data  = rd;
endmodule

// File: rtl/lsq_detrend_chk.sv
module lsq_detrend_chk #(
  parameter int M = 20,
  parameter int OUT_W = 30
) (
  input logic                    clk,
  input logic                    rst_n,
  input logic                    in_ready,
  input logic                    out_valid,
  input logic                    out_ready,
  input logic                    out_last,
  input logic signed [OUT_W-1:0] out_data,
  input logic signed [OUT_W-1:0] out_slope,
  input logic signed [OUT_W-1:0] out_icpt,
  input logic signed [OUT_W-1:0] out_amp
);
  localparam int BW = $clog2(M);
  logic [BW-1:0] beat_q;

  always_ff @(posedge clk) begin
    if (!rst_n) beat_q <= '0;
    else if (out_valid && out_ready)
      beat_q <= (beat_q == BW'(M - 1)) ? '0 : beat_q + BW'(1);
  end

  a_r1_reset_state: assert property (@(posedge clk)
    !rst_n |=> (in_ready && !out_valid));

  a_r2_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
    in_ready |-> !out_valid);

  a_r8_stall_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data) &&
      $stable(out_last) && $stable(out_slope) && $stable(out_icpt) && $stable(out_amp)));

  a_r8_last_beat: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (out_last == (beat_q == BW'(M - 1))));

  a_r7_amp_nonneg: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !out_amp[OUT_W-1]);
endmodule

bind lsq_detrend lsq_detrend_chk #(.M(M), .OUT_W(OUT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_last(out_last), .out_data(out_data),
  .out_slope(out_slope), .out_icpt(out_icpt), .out_amp(out_amp)
);

// File: tb/test_lsq_detrend.sv
`timescale 1ns/1ps
module test_lsq_detrend;
  localparam int M = 20;
  localparam int IN_W = 12;
  localparam int SCALE_SH = 4;
  localparam int RSH = 20;
  localparam int OUT_W = IN_W + SCALE_SH + 2 * $clog2(M + 1) + 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, in_start = 1'b0, out_ready = 1'b1;
  logic signed [IN_W-1:0] in_data = '0;
  logic in_ready, out_valid, out_last;
  logic signed [OUT_W-1:0] out_data, out_slope, out_icpt, out_amp;

  always #4 clk = ~clk;

  lsq_detrend #(.M(M), .IN_W(IN_W), .SCALE_SH(SCALE_SH), .RSH(RSH)) i_lsq_detrend (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_start(in_start), .in_data(in_data), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .out_slope(out_slope), .out_icpt(out_icpt), .out_amp(out_amp)
  );

  int checks = 0, failures = 0;
  longint cyc = 0;
  int stim[M];
  longint exp_q[M];
  longint exp_sl, exp_ic, exp_am;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc > 150000) begin
      failures = failures + 1;
      $display("FAIL watchdog: run hung, got cycle %0d exp below 150000", cyc);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  task automatic chk(input string req, input string what, input longint act, input longint expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s %s: got %0d exp %0d", req, what, act, expv);
    end
  endtask

  // reference from the requirement formulas R3..R7
  function automatic void compute_ref();
    longint p[M];
    longint s = 0, ym, c = 0, rm, rv, v2, mx, mn;
    for (int i = 0; i < M; i++) begin
      p[i] = longint'(stim[i]) * (longint'(1) << SCALE_SH);
      s += p[i];
    end
    rm = ((longint'(1) << RSH) + M / 2) / M;
    ym = (s * rm) >>> RSH;
    v2 = longint'(M) * (longint'(M) * M - 1) / 3;
    rv = ((longint'(1) << RSH) + v2 / 2) / v2;
    for (int i = 0; i < M; i++) c += longint'(2 * i - (M - 1)) * (p[i] - ym);
    exp_sl = (c * rv) >>> (RSH - 1);
    exp_ic = ym - ((exp_sl * (M - 1)) >>> 1);
    mx = -(longint'(1) << 60);
    mn = (longint'(1) << 60);
    for (int i = 0; i < M; i++) begin
      exp_q[i] = p[i] - exp_ic - exp_sl * i;
      if (exp_q[i] > mx) mx = exp_q[i];
      if (exp_q[i] < mn) mn = exp_q[i];
    end
    exp_am = (mx - mn) >>> 1;
  endfunction

  task automatic send_px(input int v, input logic st);
    @(negedge clk);
    in_valid = 1'b1; in_start = st; in_data = IN_W'(v);
    @(posedge clk);
    #1 in_valid = 1'b0; in_start = 1'b0;
  endtask

  task automatic send_profile(input bit gaps);
    for (int i = 0; i < M; i++) begin
      send_px(stim[i], i == 0);
      if (gaps && (i % 4 == 2)) @(negedge clk);
    end
  endtask

  task automatic collect(input string req, input bit stalls);
    int waitc = 0;
    longint hd;
    logic hl;
    @(negedge clk);
    chk("R2", "in_ready low after full profile", longint'(in_ready), 0);
    while (!out_valid && waitc < 300) begin
      @(negedge clk);
      waitc++;
    end
    for (int b = 0; b < M; b++) begin
      if (stalls && (b % 5 == 1)) begin
        out_ready = 1'b0;
        hd = longint'(out_data); hl = out_last;
        @(posedge clk);
        @(negedge clk);
        chk("R8", "data held while stalled", longint'(out_data), hd);
        chk("R8", "last held while stalled", longint'(out_last), longint'(hl));
        out_ready = 1'b1;
      end
      chk("R8", "out_valid during drain", longint'(out_valid), 1);
      chk("R2", "in_ready low during drain", longint'(in_ready), 0);
      chk(req, $sformatf("q[%0d]", b), longint'(out_data), exp_q[b]);
      chk("R8", $sformatf("out_last beat %0d", b), longint'(out_last), longint'(b == M - 1));
      if (b == 0) begin
        chk("R4", "slope", longint'(out_slope), exp_sl);
        chk("R5", "intercept", longint'(out_icpt), exp_ic);
        chk("R7", "amplitude", longint'(out_amp), exp_am);
      end
      @(posedge clk);
      @(negedge clk);
    end
    chk("R2", "in_ready back after drain", longint'(in_ready), 1);
    chk("R8", "out_valid low after drain", longint'(out_valid), 0);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1", "in_ready after reset", longint'(in_ready), 1);
    chk("R1", "out_valid after reset", longint'(out_valid), 0);
  endtask

  task automatic t_flat();
    for (int i = 0; i < M; i++) stim[i] = 100;
    compute_ref();
    chk("R3", "flat reference slope", exp_sl, 0);
    send_profile(1'b0);
    collect("R3", 1'b0);
  endtask

  task automatic t_ramp();
    for (int i = 0; i < M; i++) stim[i] = 5 * i - 40;
    compute_ref();
    send_profile(1'b0);
    collect("R5", 1'b0);
  endtask

  task automatic t_tri_stall();
    for (int i = 0; i < M; i++)
      stim[i] = (((i % 6) < 3) ? (i % 6) : (6 - (i % 6))) * 300 - 450 + 3 * i;
    compute_ref();
    send_profile(1'b1);
    collect("R6", 1'b1);
  endtask

  task automatic t_full_scale();
    for (int i = 0; i < M; i++) stim[i] = (i % 2 == 0) ? 2047 : -2048;
    compute_ref();
    send_profile(1'b0);
    collect("R9", 1'b0);
    for (int i = 0; i < M; i++) stim[i] = -2048;
    compute_ref();
    send_profile(1'b0);
    collect("R9", 1'b0);
    for (int i = 0; i < M; i++) stim[i] = (i < M / 2) ? -2048 : 2047;
    compute_ref();
    send_profile(1'b0);
    collect("R9", 1'b1);
  endtask

  task automatic t_discard();
    for (int i = 0; i < 5; i++) send_px(1500 - 700 * i, 1'b0);
    for (int i = 0; i < M; i++) stim[i] = 20 * i - 300 + ((i % 3) * 50);
    compute_ref();
    send_profile(1'b0);
    collect("R2", 1'b0);
  endtask

  task automatic t_restart();
    for (int i = 0; i < 7; i++) send_px(-1900 + 600 * i, i == 0);
    for (int i = 0; i < M; i++) stim[i] = 400 - 30 * i + ((i % 4) * 90);
    compute_ref();
    send_profile(1'b0);
    collect("R2", 1'b0);
  endtask

  task automatic t_random();
    for (int n = 0; n < 5; n++) begin
      for (int i = 0; i < M; i++) stim[i] = int'($urandom_range(4095)) - 2048;
      compute_ref();
      send_profile(n % 2 == 1);
      collect("R6", n % 2 == 0);
    end
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;
    t_reset();
    t_ramp();
    t_tri_stall();
    t_full_scale();
    t_flat();        // small span right after full-scale span: R7 restart
    t_discard();
    t_restart();
    t_random();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule